// File: doc/BRIEF.md
# Paged Serial Configuration Memory Reader

This block is the read side of a serial configuration store. It streams words from a synchronous memory array to an FPGA one bit per rising edge of the configuration clock, most significant bit first. A word-address counter and a bit counter set the position in the stream. The next word is fetched while the last bit of the current word is on the pin, so the stream has no gaps between words.

The array can be split into four equal quarters. A two-bit page code selects which quarter is read, or paging can be switched off so that the whole array is streamed. When the counter has finished the top word of the active range, an active-low cascade output asserts so that the next device in a daisy chain can take over. The data pin has its own output enable, which lets it share a bus. While the serial-enable input is low, the read path is frozen and the page inputs are ignored.

Top module: `cfgr_page_reader`

## Requirements
- R1: While `rst_oe` is low, both counters are cleared at once, `data_oe` and `mem_rd_en` are 0 and `cascade_n` is 1. On the first enabled edge after release, the block fetches the base word of the selected range: `mem_rd_en`=1 and `mem_addr`=base in the cycle before that edge.
- R2: `data_oe` is 1 exactly when `ser_en`=1, `rst_oe`=1 and `cs_n`=0. Otherwise it is 0.
- R3: Each word is WW bits wide and is shifted out MSB first, one bit per enabled `dclk` edge. The word at range offset n is followed directly by the word at offset n+1. During the last bit of a word, `mem_rd_en`=1 with the address of the next word, so the data pin has no idle cycle.
- R4: While `cs_n`=1 (with `ser_en`=1), `standby`=1, no memory read is issued and both counters hold. When `cs_n` returns low, the stream resumes at the same bit.
- R5: With `page_en`=1, page code k (0 to 3) restricts reads to addresses k·2^(AW-2) through (k+1)·2^(AW-2)-1. The upper two address bits equal the page code.
- R6: With `page_en`=0, `page_sel` is ignored and the stream covers addresses 0 through 2^AW-1.
- R7: `cascade_n` falls on the edge that completes the last bit of the top word of the active range. The counter then saturates, and no further reads are issued.
- R8: Once asserted, `cascade_n` equals `cs_n` until `rst_oe` goes low. After that it stays 1 until the whole range has been streamed again.
- R9: While `ser_en`=0, counters and the held page setting are frozen. No reads occur, `data_oe`=0, `cascade_n`=1 and `standby`=0. `cs_n`, `page_en` and `page_sel` have no effect, and `mem_addr` keeps showing the current word of the held page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dclk | input | 1 | Configuration clock; one bit per rising edge |
| rst_oe | input | 1 | Low: asynchronous counter clear; high: output enable |
| cs_n | input | 1 | Active-low chip select |
| ser_en | input | 1 | High: serial read mode; low: programming mode |
| page_en | input | 1 | High: read one quarter of the array |
| page_sel | input | 2 | Quarter code when paging is on |
| mem_rd_en | output | 1 | Synchronous read strobe to the array |
| mem_addr | output | AW | Word address to the array |
| mem_rdata | input | WW | Word returned one edge after the strobe |
| data_out | output | 1 | Serial data bit |
| data_oe | output | 1 | Drive enable for the data pin |
| cascade_n | output | 1 | Active-low end-of-range cascade |
| standby | output | 1 | High while deselected in serial mode |

## Verification
The assertions check on every cycle that the counters hold in standby, in programming mode and after saturation. They also check that a read is issued only during the last bit of a word or the first fetch, that every wrap advances the address by exactly one, that paged reads stay inside the selected quarter, and that an asserted cascade implies chip select is low. Only the bench scenarios can show that the bit stream matches the stored words in order with no gap, that each page code maps to the right quarter, that a stream paused by standby or programming mode resumes on the exact bit where it stopped, and that the cascade release-and-rearm sequence around `rst_oe` is correct.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;

    localparam int PAGE_BITS = 2;

    typedef struct packed {
        logic                 paged;
        logic [PAGE_BITS-1:0] sel;
    } page_cfg_t;

endpackage

// File: rtl/cfgr_page_map.sv
module cfgr_page_map
    import cfgr_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic [AW-1:0] off_i,
    input  page_cfg_t     cfg_i,
    output logic [AW-1:0] addr_o,
    output logic          at_top_o
);

    localparam int OFF_W = AW - PAGE_BITS;

    // Paged: page code on the upper bits, offset wraps inside the quarter.
    always_comb begin
        if (cfg_i.paged) begin
            addr_o   = {cfg_i.sel, off_i[OFF_W-1:0]};
            at_top_o = &off_i[OFF_W-1:0];
        end else begin
            addr_o   = off_i;
            at_top_o = &off_i;
        end
    end

endmodule

// File: rtl/cfgr_stream_ctrl.sv
module cfgr_stream_ctrl
    import cfgr_pkg::*;
#(
    parameter int AW = 20,
    parameter int WW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_en,
    input  logic                 cs_n,
    input  logic                 page_en,
    input  logic [PAGE_BITS-1:0] page_sel,
    output logic                 mem_rd_en,
    output logic [AW-1:0]        mem_addr,
    output logic [$clog2(WW)-1:0] bit_idx,
    output logic                 done
);

    localparam int BW = $clog2(WW);
    localparam logic [BW-1:0] LAST_BIT = BW'(WW - 1);

    typedef struct packed {
        logic [AW-1:0] off;
        logic [BW-1:0] bitc;
        logic          fill;
        logic          done;
        page_cfg_t     cfg;
    } st_t;

    st_t           st_d, st_q;
    page_cfg_t     cfg_eff;
    logic [AW-1:0] cur_addr;
    logic          at_top;
    logic          act;
    logic          rd_en_d;
    logic [AW-1:0] rd_addr_d;

    // Page setting follows the pins only in serial mode.
    always_comb begin
        if (ser_en) begin
            cfg_eff.paged = page_en;
            cfg_eff.sel   = page_sel;
        end else begin
            cfg_eff = st_q.cfg;
        end
    end

    cfgr_page_map #(.AW(AW)) u_map (
        .off_i   (st_q.off),
        .cfg_i   (cfg_eff),
        .addr_o  (cur_addr),
        .at_top_o(at_top)
    );

    assign act = ser_en & ~cs_n & rst_n;

    always_comb begin
        st_d      = st_q;
        st_d.cfg  = cfg_eff;
        rd_en_d   = 1'b0;
        rd_addr_d = cur_addr;
        if (act) begin
            if (st_q.fill) begin
                rd_en_d   = 1'b1;
                st_d.fill = 1'b0;
            end else if (!st_q.done) begin
                if (st_q.bitc == LAST_BIT) begin
                    st_d.bitc = '0;
                    if (at_top) begin
                        st_d.done = 1'b1;
                    end else begin
                        // Prefetch: the word lands on this edge.
                        rd_en_d   = 1'b1;
                        rd_addr_d = cur_addr + AW'(1);
                        st_d.off  = st_q.off + AW'(1);
                    end
                end else begin
                    st_d.bitc = st_q.bitc + BW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.off  <= '0;
            st_q.bitc <= '0;
            st_q.fill <= 1'b1;
            st_q.done <= 1'b0;
            st_q.cfg  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_rd_en = rd_en_d;
    assign mem_addr  = rd_addr_d;
    assign bit_idx   = st_q.bitc;
    assign done      = st_q.done;

    // R4: deselected in serial mode, position frozen
    a_r4_hold_in_standby: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_en && cs_n) |=> ($stable(st_q.off) && $stable(st_q.bitc)));

    // R9: programming mode freezes position and held page
    a_r9_isp_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_en |=> ($stable(st_q.off) && $stable(st_q.bitc) && $stable(st_q.cfg)));

    // R3: a word wrap advances the offset by one
    a_r3_wrap_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (act && !st_q.fill && !st_q.done && st_q.bitc == LAST_BIT && !at_top)
        |=> (st_q.bitc == '0 && st_q.off == $past(st_q.off) + AW'(1)));

    // R3: reads outside the first fetch only during the last bit
    a_r3_prefetch_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && !st_q.fill) |-> (st_q.bitc == LAST_BIT));

    // R7: saturated counter never moves
    a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> ($stable(st_q.off) && !mem_rd_en));

endmodule

// File: rtl/cfgr_pin_drive.sv
module cfgr_pin_drive (
    input  logic ser_en,
    input  logic rst_n,
    input  logic cs_n,
    input  logic done,
    output logic data_oe,
    output logic cascade_n,
    output logic standby
);

    always_comb begin
        data_oe   = ser_en & rst_n & ~cs_n;
        standby   = ser_en & cs_n;
        // After the range end, mirror the select pin down the chain.
        cascade_n = (ser_en & done) ? cs_n : 1'b1;
    end

endmodule

// File: rtl/cfgr_page_reader.sv
module cfgr_page_reader
    import cfgr_pkg::*;
#(
    parameter int AW = 20,
    parameter int WW = 16
) (
    input  logic          dclk,
    input  logic          rst_oe,
    input  logic          cs_n,
    input  logic          ser_en,
    input  logic          page_en,
    input  logic [1:0]    page_sel,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_addr,
    input  logic [WW-1:0] mem_rdata,
    output logic          data_out,
    output logic          data_oe,
    output logic          cascade_n,
    output logic          standby
);

    localparam int BW = $clog2(WW);

    logic [BW-1:0] bit_idx;
    logic          done;
    logic [WW-1:0] shifted;

    cfgr_stream_ctrl #(.AW(AW), .WW(WW)) u_ctrl (
        .clk      (dclk),
        .rst_n    (rst_oe),
        .ser_en   (ser_en),
        .cs_n     (cs_n),
        .page_en  (page_en),
        .page_sel (page_sel),
        .mem_rd_en(mem_rd_en),
        .mem_addr (mem_addr),
        .bit_idx  (bit_idx),
        .done     (done)
    );

    cfgr_pin_drive u_pins (
        .ser_en   (ser_en),
        .rst_n    (rst_oe),
        .cs_n     (cs_n),
        .done     (done),
        .data_oe  (data_oe),
        .cascade_n(cascade_n),
        .standby  (standby)
    );

    // Read word stays on the array output until the next strobe.
    assign shifted  = mem_rdata << bit_idx;
    assign data_out = shifted[WW-1];

    // R5: paged reads land in the selected quarter
    a_r5_page_window: assert property (@(posedge dclk) disable iff (!rst_oe)
        (ser_en && page_en && mem_rd_en) |-> (mem_addr[AW-1 -: 2] == page_sel));

    // R8: an asserted cascade implies the device is selected
    a_r8_casc_needs_cs: assert property (@(posedge dclk) disable iff (!rst_oe)
        !cascade_n |-> !cs_n);

endmodule

// File: tb/tb_cfgr_page_reader.sv
`timescale 1ns/1ps
module tb_cfgr_page_reader;

    localparam int AW = 6;
    localparam int WW = 16;
    localparam int QW = 1 << (AW - 2);

    logic          dclk = 1'b0;
    logic          rst_oe, cs_n, ser_en, page_en;
    logic [1:0]    page_sel;
    logic          mem_rd_en;
    logic [AW-1:0] mem_addr;
    logic [WW-1:0] mem_rdata;
    logic          data_out, data_oe, cascade_n, standby;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 dclk = ~dclk;

    cfgr_page_reader #(.AW(AW), .WW(WW)) dut (
        .dclk(dclk), .rst_oe(rst_oe), .cs_n(cs_n), .ser_en(ser_en),
        .page_en(page_en), .page_sel(page_sel), .mem_rd_en(mem_rd_en),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .data_out(data_out),
        .data_oe(data_oe), .cascade_n(cascade_n), .standby(standby)
    );

    function automatic logic [WW-1:0] wfn(input int a);
        return 16'((a * 16'h03B1) ^ 16'h5AC3 ^ (a << 11));
    endfunction

    always_ff @(posedge dclk) if (mem_rd_en) mem_rdata <= wfn(int'(mem_addr));

    task automatic chk(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (ok !== 1'b1) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge dclk);
        @(negedge dclk);
    endtask

    task automatic do_reset(input logic pen, input logic [1:0] sel, input int base);
        rst_oe = 1'b0; cs_n = 1'b0; ser_en = 1'b1; page_en = pen; page_sel = sel;
        #1;
        tick();
        rst_oe = 1'b1;
        #1;
        chk(mem_rd_en == 1'b1, "R1 first fetch strobe", mem_rd_en, 1);
        chk(int'(mem_addr) == base, "R1 first fetch base", mem_addr, base);
        tick();
    endtask

    task automatic check_word(input int a, input int hi, input int lo, input bit top);
        logic [WW-1:0] w;
        w = wfn(a);
        for (int b = hi; b >= lo; b--) begin
            chk(data_out == w[b], "R3 serial bit", data_out, w[b]);
            chk(cascade_n == 1'b1, "R8 cascade idle in stream", cascade_n, 1);
            if (b == 0 && !top) begin
                chk(mem_rd_en == 1'b1, "R3 prefetch strobe", mem_rd_en, 1);
                chk(int'(mem_addr) == a + 1, "R3 prefetch addr", mem_addr, a + 1);
            end
            tick();
        end
    endtask

    task automatic stream(input int base, input int first, input int last, input int top_off);
        for (int w = first; w <= last; w++)
            check_word(base + w, WW - 1, 0, w == top_off);
    endtask

    task automatic t_reset();
        rst_oe = 1'b0; cs_n = 1'b0; ser_en = 1'b1; page_en = 1'b0; page_sel = 2'd0;
        #1;
        chk(data_oe == 1'b0, "R1 oe in reset", data_oe, 0);
        chk(cascade_n == 1'b1, "R1 cascade in reset", cascade_n, 1);
        chk(mem_rd_en == 1'b0, "R1 no read in reset", mem_rd_en, 0);
        tick();
    endtask

    task automatic t_page(input int k);
        int base;
        base = k * QW;
        do_reset(1'b1, 2'(k), base);
        chk(data_oe == 1'b1, "R2 oe active", data_oe, 1);
        stream(base, 0, QW - 1, QW - 1);
        chk(cascade_n == 1'b0, "R7 cascade at page top", cascade_n, 0);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk(mem_rd_en == 1'b0, "R7 saturated no read", mem_rd_en, 0);
            chk(cascade_n == 1'b0, "R8 cascade held low", cascade_n, 0);
        end
        cs_n = 1'b1; #1;
        chk(cascade_n == 1'b1, "R8 cascade follows cs high", cascade_n, 1);
        cs_n = 1'b0; #1;
        chk(cascade_n == 1'b0, "R8 cascade follows cs low", cascade_n, 0);
        rst_oe = 1'b0; #1;
        chk(cascade_n == 1'b1, "R8 cascade released by oe", cascade_n, 1);
        chk(data_oe == 1'b0, "R2 oe low in reset", data_oe, 0);
        tick();
        rst_oe = 1'b1; #1;
        chk(cascade_n == 1'b1, "R8 cascade stays high", cascade_n, 1);
        chk(int'(mem_addr) == base && mem_rd_en, "R1 restart at base", mem_addr, base);
        tick();
        check_word(base, WW - 1, 0, 1'b0);
    endtask

    task automatic t_full();
        do_reset(1'b0, 2'b11, 0);
        stream(0, 0, (1 << AW) - 1, (1 << AW) - 1);
        chk(cascade_n == 1'b0, "R6 cascade at array top", cascade_n, 0);
    endtask

    task automatic t_standby();
        int base;
        logic [WW-1:0] w;
        base = QW;
        do_reset(1'b1, 2'd1, base);
        stream(base, 0, 2, -1);
        check_word(base + 3, WW - 1, 6, 1'b0);
        cs_n = 1'b1; #1;
        chk(data_oe == 1'b0, "R2 oe off when deselected", data_oe, 0);
        chk(standby == 1'b1, "R4 standby flag", standby, 1);
        for (int i = 0; i < 4; i++) begin
            tick();
            chk(mem_rd_en == 1'b0, "R4 no read in standby", mem_rd_en, 0);
        end
        cs_n = 1'b0; #1;
        w = wfn(base + 3);
        chk(data_out == w[5], "R4 resume same bit", data_out, w[5]);
        chk(standby == 1'b0, "R4 standby cleared", standby, 0);
        check_word(base + 3, 5, 0, 1'b0);
        stream(base, 4, QW - 1, QW - 1);
        chk(cascade_n == 1'b0, "R5 page 1 ends with cascade", cascade_n, 0);
    endtask

    task automatic t_isp();
        int base;
        logic [WW-1:0] w;
        base = 2 * QW;
        do_reset(1'b1, 2'd2, base);
        stream(base, 0, 4, -1);
        check_word(base + 5, WW - 1, 9, 1'b0);
        ser_en = 1'b0; page_sel = 2'd0; page_en = 1'b0; cs_n = 1'b1; #1;
        chk(data_oe == 1'b0, "R9 oe off", data_oe, 0);
        chk(standby == 1'b0, "R9 no standby", standby, 0);
        chk(cascade_n == 1'b1, "R9 cascade high", cascade_n, 1);
        for (int i = 0; i < 5; i++) begin
            cs_n = i[0];
            tick();
            chk(mem_rd_en == 1'b0, "R9 no read", mem_rd_en, 0);
            chk(int'(mem_addr) == base + 5, "R9 held page addr", mem_addr, base + 5);
        end
        page_en = 1'b1; page_sel = 2'd2; cs_n = 1'b0; ser_en = 1'b1; #1;
        w = wfn(base + 5);
        chk(data_out == w[8], "R9 resume same bit", data_out, w[8]);
        check_word(base + 5, 8, 0, 1'b0);
        stream(base, 6, QW - 1, QW - 1);
        chk(cascade_n == 1'b0, "R5 page 2 ends with cascade", cascade_n, 0);
    endtask

    initial begin
        for (int c = 0; c < 200000; c++) begin
            @(posedge dclk);
            if (finished) break;
        end
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_oe = 1'b0; cs_n = 1'b1; ser_en = 1'b1; page_en = 1'b0; page_sel = 2'd0;
        @(negedge dclk);
        t_reset();
        t_page(0);
        t_page(3);
        t_full();
        t_standby();
        t_isp();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule